// File: doc/BRIEF.md
# Pulse-Step Backlight Dimmer

This block controls a backlight driver that has 33 brightness steps and listens on one control wire. The driver moves down one step for each short low pulse it sees, and it wraps from the lowest step back to the top. A brightness request is an 8-bit value with a one-cycle strobe. The block scales the request to a step index and works out how many pulses bring the driver from the step it last set to the new one. It then emits exactly that many pulses. All pulse and hold timing comes from a microsecond tick divided down from the core clock.

The block has two special sequences. A target of step 0 switches the driver off: the wire is pulled low and held low for an off-hold interval. Leaving the off state takes a wake preamble: the wire is held high for a fixed interval, after which the driver is known to sit at the top step. Pulses are then counted from that top step. If a request arrives while a sequence is running, it waits and is applied once that sequence has finished. `busy_o` marks the time from an accepted request until its sequence completes.

Top module: `bl_step_dimmer`

## Requirements
- R1: The 8-bit request maps to step index floor(request x 34 / 256), which gives 0 for requests 0..7, 1 for requests 8..15 and 33 for request 255.
- R2: If the mapped step equals the last applied step, the wire does not move, and `busy_o` is high for exactly one cycle after the strobe.
- R3: A mapped step of 0 drives the wire low on the cycle after the request is taken. The wire is held low for OFF_HOLD_US microseconds, stays low afterwards, and the last applied step becomes 0.
- R4: If the last applied step is 0 and the target is non-zero, the wire goes high and stays high for WAKE_US microseconds before any pulse. The pulse count is then worked out from a current step of 33.
- R5: The number of low pulses is (current step - target step + 33) mod 33.
- R6: Each pulse is exactly CLKS_PER_US core cycles low followed by CLKS_PER_US core cycles high. When no sequence runs and the last step is non-zero, the wire rests high.
- R7: The last applied step is updated to the target only when the sequence ends, never partway through.
- R8: After reset the last applied step is 33, the wire is high and `busy_o` is low.
- R9: A request that arrives while a sequence runs is held and started only after that sequence ends. If several such requests arrive, only the latest is kept, and pulses of two requests are never interleaved.
- R10: `busy_o` rises on the cycle after the strobe and falls on the edge where the final phase of the sequence completes. A phase of N microseconds lasts exactly N x CLKS_PER_US cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle strobe for a brightness request |
| req_level_i | input | 8 | Requested brightness, 0 (off) to 255 (full) |
| dim_pin_o | output | 1 | Control wire to the step-dimming driver |
| busy_o | output | 1 | A request is pending or its sequence is running |

## Verification
The hardest situation to reach is a request that lands while a long pulse train is still running, particularly when a second request overwrites the first before either is applied. The bench gets there by starting a train and then injecting two strobes partway through it, from inside the measuring loop. It then checks that the combined falling-edge count matches the first train plus a train toward only the last injected level, and that no pulse narrower than one microsecond ever appears. Reaching the wake preamble requires first switching the driver off through the full off hold, so the sequence of scenarios is arranged to pass through the off state twice.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OFF  = 3'd1,
    ST_WAKE = 3'd2,
    ST_LO   = 3'd3,
    ST_HI   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/bl_us_tick.sv
module bl_us_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bl_req_hold.sv
module bl_req_hold #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [LW-1:0] level_i,
  input  logic          take_i,
  output logic          pend_o,
  output logic [LW-1:0] level_o
);
  // latest request wins; a strobe in the take cycle stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      level_o <= '0;
    end else if (valid_i) begin
      pend_o  <= 1'b1;
      level_o <= level_i;
    end else if (take_i) begin
      pend_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/bl_step_calc.sv
module bl_step_calc #(
  parameter int LW       = 8,
  parameter int MAX_STEP = 33
) (
  input  logic [LW-1:0]                    level_i,
  input  logic [$clog2(MAX_STEP+1)-1:0]    last_i,
  output logic [$clog2(MAX_STEP+1)-1:0]    tgt_o,
  output logic [$clog2(MAX_STEP+1)-1:0]    cnt_o,
  output logic                             wake_o,
  output logic                             same_o
);
  localparam int SW = $clog2(MAX_STEP + 1);
  localparam int PW = LW + SW;

  logic [PW-1:0] prod;
  logic [SW-1:0] cur;
  logic [SW:0]   diff;

  always_comb begin
    prod   = PW'(level_i) * PW'(MAX_STEP + 1);
    tgt_o  = SW'(prod >> LW);
    wake_o = (last_i == '0);
    same_o = (tgt_o == last_i);
    cur    = wake_o ? SW'(MAX_STEP) : last_i;
    if (cur >= tgt_o) diff = {1'b0, cur} - {1'b0, tgt_o};
    else              diff = {1'b0, cur} + (SW+1)'(MAX_STEP) - {1'b0, tgt_o};
    cnt_o  = (diff >= (SW+1)'(MAX_STEP)) ? SW'(diff - (SW+1)'(MAX_STEP)) : SW'(diff);
  end
endmodule

// File: rtl/bl_seq_fsm.sv
module bl_seq_fsm
  import bl_dim_pkg::*;
#(
  parameter int MAX_STEP    = 33,
  parameter int OFF_HOLD_US = 2000,
  parameter int WAKE_US     = 40,
  parameter int LO_US       = 1,
  parameter int HI_US       = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          pend_i,
  input  logic [$clog2(MAX_STEP+1)-1:0] tgt_i,
  input  logic [$clog2(MAX_STEP+1)-1:0] cnt_i,
  input  logic                          wake_i,
  input  logic                          same_i,
  input  logic                          tick_i,
  output logic                          take_o,
  output logic                          tclr_o,
  output logic                          pin_o,
  output logic [$clog2(MAX_STEP+1)-1:0] last_o,
  output logic [$clog2(MAX_STEP+1)-1:0] cnt_o,
  output seq_state_e                    state_o
);
  localparam int SW = $clog2(MAX_STEP + 1);
  localparam int T1 = (OFF_HOLD_US > WAKE_US) ? OFF_HOLD_US : WAKE_US;
  localparam int T2 = (T1 > LO_US) ? T1 : LO_US;
  localparam int TM = (T2 > HI_US) ? T2 : HI_US;
  localparam int TW = $clog2(TM + 1);

  seq_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic [SW-1:0] tgt_q;
  logic          phase_end;

  assign take_o    = (state_q == ST_IDLE) && pend_i;
  assign phase_end = tick_i && (tmr_q == TW'(1)) && (state_q != ST_IDLE);
  assign tclr_o    = take_o || phase_end;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pin_o   <= 1'b1;
      last_o  <= SW'(MAX_STEP);
      cnt_o   <= '0;
      tmr_q   <= '0;
      tgt_q   <= '0;
    end else begin
      if (tick_i && state_q != ST_IDLE && !phase_end) tmr_q <= tmr_q - 1'b1;
      unique case (state_q)
        ST_IDLE: if (pend_i && !same_i) begin
          tgt_q <= tgt_i;
          cnt_o <= cnt_i;
          if (tgt_i == '0) begin
            state_q <= ST_OFF;
            pin_o   <= 1'b0;
            tmr_q   <= TW'(OFF_HOLD_US);
          end else if (wake_i) begin
            state_q <= ST_WAKE;
            pin_o   <= 1'b1;
            tmr_q   <= TW'(WAKE_US);
          end else begin
            state_q <= ST_LO;
            pin_o   <= 1'b0;
            tmr_q   <= TW'(LO_US);
          end
        end
        ST_OFF: if (phase_end) begin
          state_q <= ST_IDLE;
          last_o  <= '0;
        end
        ST_WAKE: if (phase_end) begin
          if (cnt_o == '0) begin
            state_q <= ST_IDLE;
            last_o  <= tgt_q;
          end else begin
            state_q <= ST_LO;
            pin_o   <= 1'b0;
            tmr_q   <= TW'(LO_US);
          end
        end
        ST_LO: if (phase_end) begin
          state_q <= ST_HI;
          pin_o   <= 1'b1;
          tmr_q   <= TW'(HI_US);
        end
        ST_HI: if (phase_end) begin
          cnt_o <= cnt_o - 1'b1;
          if (cnt_o == SW'(1)) begin
            state_q <= ST_IDLE;
            last_o  <= tgt_q;
          end else begin
            state_q <= ST_LO;
            pin_o   <= 1'b0;
            tmr_q   <= TW'(LO_US);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bl_step_dimmer.sv
module bl_step_dimmer
  import bl_dim_pkg::*;
#(
  parameter int LW          = 8,
  parameter int MAX_STEP    = 33,
  parameter int CLKS_PER_US = 4,
  parameter int OFF_HOLD_US = 2000,
  parameter int WAKE_US     = 40,
  parameter int LO_US       = 1,
  parameter int HI_US       = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [LW-1:0] req_level_i,
  output logic          dim_pin_o,
  output logic          busy_o
);
  localparam int SW = $clog2(MAX_STEP + 1);

  logic          pend, take, tclr, tick, wake, same;
  logic [LW-1:0] pend_level;
  logic [SW-1:0] tgt, cnt, last_step, pulse_cnt;
  seq_state_e    seq_state;

  bl_us_tick #(.DIV(CLKS_PER_US)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tclr), .tick_o(tick)
  );

  bl_req_hold #(.LW(LW)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(req_valid_i), .level_i(req_level_i),
    .take_i(take), .pend_o(pend), .level_o(pend_level)
  );

  bl_step_calc #(.LW(LW), .MAX_STEP(MAX_STEP)) u_calc (
    .level_i(pend_level), .last_i(last_step), .tgt_o(tgt), .cnt_o(cnt),
    .wake_o(wake), .same_o(same)
  );

  bl_seq_fsm #(
    .MAX_STEP(MAX_STEP), .OFF_HOLD_US(OFF_HOLD_US), .WAKE_US(WAKE_US),
    .LO_US(LO_US), .HI_US(HI_US)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .tgt_i(tgt), .cnt_i(cnt),
    .wake_i(wake), .same_i(same), .tick_i(tick), .take_o(take), .tclr_o(tclr),
    .pin_o(dim_pin_o), .last_o(last_step), .cnt_o(pulse_cnt), .state_o(seq_state)
  );

  assign busy_o = pend || (seq_state != ST_IDLE);
endmodule

// File: rtl/bl_step_dimmer_chk.sv
module bl_step_dimmer_chk
  import bl_dim_pkg::*;
#(
  parameter int MAX_STEP = 33
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_valid_i,
  input logic                          busy_o,
  input logic                          dim_pin_o,
  input logic [$clog2(MAX_STEP+1)-1:0] last_step,
  input logic [$clog2(MAX_STEP+1)-1:0] pulse_cnt,
  input seq_state_e                    seq_state
);
  localparam int SW = $clog2(MAX_STEP + 1);

  p_idle_rest_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == ST_IDLE && last_step != '0) |-> dim_pin_o);

  p_off_stays_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == ST_IDLE && last_step == '0) |-> !dim_pin_o);

  p_last_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_step) |-> (seq_state == ST_IDLE));

  p_pin_needs_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dim_pin_o) |-> $past(busy_o));

  p_busy_after_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> busy_o);

  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= SW'(MAX_STEP - 1));
endmodule

bind bl_step_dimmer bl_step_dimmer_chk #(.MAX_STEP(MAX_STEP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .dim_pin_o(dim_pin_o), .last_step(last_step), .pulse_cnt(pulse_cnt),
  .seq_state(seq_state)
);

// File: tb/tb_bl_step_dimmer.sv
module tb_bl_step_dimmer;
  localparam int CLK_PERIOD = 10;
  localparam int K          = 4;
  localparam int OFF_US     = 2000;
  localparam int WAKE_US    = 40;
  localparam int TOP        = 33;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_level = 8'd0;
  logic       pin, busy;

  int n_chk = 0, n_err = 0, last_m = TOP;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_step_dimmer #(
    .CLKS_PER_US(K), .OFF_HOLD_US(OFF_US), .WAKE_US(WAKE_US)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_level_i(req_level),
    .dim_pin_o(pin), .busy_o(busy)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int step_of(input int lv);
    return (lv * 34) / 256;
  endfunction

  function automatic int npulse(input int cur, input int tgt);
    return (cur - tgt + TOP) % TOP;
  endfunction

  task automatic drive_req(input int lv);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = 8'(lv);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // observe until busy drops; optional two injected requests at inj_cyc
  task automatic measure(input int inj_cyc, input int inj_a, input int inj_b,
                         output int falls, output int cycles, output int minlo,
                         output int maxlo, output int minhi, output int prehi);
    bit prev;
    int lo_run, hi_run;
    prev = pin; lo_run = 0; hi_run = 0;
    falls = 0; cycles = 0; minlo = 1000000; maxlo = 0; minhi = 1000000; prehi = 0;
    while (busy && cycles < 30000) begin
      @(negedge clk);
      cycles++;
      if (inj_cyc != 0 && cycles == inj_cyc)     begin req_valid = 1'b1; req_level = 8'(inj_a); end
      if (inj_cyc != 0 && cycles == inj_cyc + 1) req_level = 8'(inj_b);
      if (inj_cyc != 0 && cycles == inj_cyc + 2) req_valid = 1'b0;
      if (!pin) begin
        if (prev) begin
          falls++;
          if (falls > 1 && hi_run < minhi) minhi = hi_run;
        end
        lo_run++;
        hi_run = 0;
      end else begin
        if (!prev && lo_run > 0) begin
          if (lo_run < minlo) minlo = lo_run;
          if (lo_run > maxlo) maxlo = lo_run;
          lo_run = 0;
        end
        hi_run++;
        if (falls == 0) prehi++;
      end
      prev = pin;
    end
  endtask

  // one request, all expectations from the model
  task automatic run_req(input int lv, input string rq);
    int tgt, n, cur, f, c, mnl, mxl, mnh, ph;
    bit wk;
    tgt = step_of(lv);
    drive_req(lv);
    chk("R10", "busy after strobe", int'(busy), 1);
    measure(0, 0, 0, f, c, mnl, mxl, mnh, ph);
    if (tgt == last_m) begin
      chk(rq, "falls when unchanged", f, 0);
      chk(rq, "busy cycles when unchanged", c, 1);
      chk(rq, "pin when unchanged", int'(pin), (last_m != 0) ? 1 : 0);
    end else if (tgt == 0) begin
      chk(rq, "falls on off", f, (last_m != 0) ? 1 : 0);
      chk("R3", "off hold cycles", c, OFF_US * K + 1);
      chk("R3", "pin after off", int'(pin), 0);
    end else begin
      wk  = (last_m == 0);
      cur = wk ? TOP : last_m;
      n   = npulse(cur, tgt);
      chk("R5", "pulse count", f, n);
      chk("R10", "busy cycles", c, (wk ? WAKE_US * K : 0) + n * 2 * K + 1);
      chk("R6", "pin rests high", int'(pin), 1);
      if (n > 0) begin
        chk("R6", "min low width", mnl, K);
        chk("R6", "max low width", mxl, K);
      end
      if (n > 1) chk("R6", "min high gap", mnh, K);
      if (wk) chk("R4", "wake preamble", ph, WAKE_US * K + ((n == 0) ? 1 : 0));
    end
    last_m = tgt;
  endtask

  task automatic t_reset;
    chk("R8", "pin after reset", int'(pin), 1);
    chk("R8", "busy after reset", int'(busy), 0);
  endtask

  task automatic t_same;     run_req(255, "R2"); endtask  // 33 == reset step
  task automatic t_pulse;    run_req(128, "R5"); endtask  // 33 -> 17, 16 pulses
  task automatic t_wrap;     run_req(200, "R5"); endtask  // 17 -> 26, 24 pulses

  // R9: train 26->17, then 40 and 136 injected; only 136 (step 18) applies
  task automatic t_hold;
    int f, c, mnl, mxl, mnh, ph, n1, n2;
    n1 = npulse(last_m, step_of(128));
    n2 = npulse(step_of(128), step_of(136));
    drive_req(128);
    measure(20, 40, 136, f, c, mnl, mxl, mnh, ph);
    chk("R9", "combined pulse count", f, n1 + n2);
    chk("R9", "min low width", mnl, K);
    chk("R9", "min high gap", mnh, K);
    chk("R9", "pin rests high", int'(pin), 1);
    last_m = step_of(136);
    run_req(136, "R7");  // step 18 already recorded: no activity
  endtask

  task automatic t_off_scale;  run_req(7, "R1"); endtask   // 7 maps to 0
  task automatic t_off_same;   run_req(0, "R2"); endtask
  task automatic t_wake;       run_req(8, "R4"); endtask   // 8 maps to 1, 32 pulses
  task automatic t_wake_full;
    run_req(0, "R3");
    run_req(255, "R4");  // wake, zero pulses
  endtask
  task automatic t_scale_one;  run_req(15, "R1"); endtask  // 33 -> 1

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_same();
    t_pulse();
    t_wrap();
    t_hold();
    t_off_scale();
    t_off_same();
    t_wake();
    t_wake_full();
    t_scale_one();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule